// File: doc/BRIEF.md
# Bus Mastership Handover Controller

This block decides, cycle by cycle, whether the processor or a single external master drives the shared system bus. The processor is the default owner. An external agent asks for the bus on a request line, and the controller answers with a grant. The grant only announces that the bus will be released. The processor keeps the bus until the access it is running ends, however many wait states that access takes. The controller then raises a bus-free indication and holds the processor so that it cannot start another access. The agent takes the bus by raising its acknowledge. The grant then drops, and the processor stays frozen until the acknowledge falls again.

The request and acknowledge inputs come from another agent, so each passes through a synchronizer of `SYNC_STAGES` flops (0 removes it). The processor busy flag is taken as synchronous. All three outputs come straight from flops.

Top module: `busarb_ctrl`

## Requirements
- R1: During synchronous reset, and on the first edge after it, grant, bus-free and hold are all low, so the processor owns the bus.
- R2: When request is high and acknowledge is low while the processor owns the bus, grant rises `SYNC_STAGES`+1 rising edges after request rises (3 edges with the default 2 stages).
- R3: While grant is high and busy is high, bus-free and hold stay low, for as long as busy stays high. Bus-free and hold rise on the first edge that samples busy low.
- R4: Bus-free is high only while grant and hold are also high.
- R5: When the synchronized acknowledge is high while bus-free is high, the external agent takes the bus. On the next edge grant and bus-free fall and hold stays high.
- R6: While the external agent owns the bus, hold stays high regardless of request. Hold falls `SYNC_STAGES`+1 edges after acknowledge falls.
- R7: A request made while acknowledge is still high is not granted. Grant stays low until acknowledge is low.
- R8: An acknowledge that arrives before bus-free is high is ignored: hold stays low and grant stays high while the processor access continues.
- R9: If request falls after grant but before acknowledge, grant, bus-free and hold return low and the processor keeps the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req_i | input | 1 | Bus request from the external agent (asynchronous) |
| grant_ack_i | input | 1 | Acknowledge from the agent, high while it owns the bus (asynchronous) |
| cpu_busy_i | input | 1 | High while the processor is running a bus access |
| bus_grant_o | output | 1 | Grant to the external agent |
| bus_free_o | output | 1 | Processor access has ended and grant is pending, so the agent may acknowledge |
| cpu_hold_o | output | 1 | Freezes the processor |

## Verification
A wrong state register shows at the ports within one edge of the input that exposes it, because every output is a flop decoded from the next state. For example, a premature release shows as bus-free or hold rising while busy is still high. A stuck ownership state shows as hold staying high past `SYNC_STAGES`+1 edges after acknowledge falls. A lost grant shows as grant falling while request is still held. The exact latencies of grant, release and return are therefore checked edge by edge. The steady outcome of each input pattern is checked separately.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  typedef enum logic [1:0] {
    OWN_CPU  = 2'd0,  // processor drives the bus
    WAIT_END = 2'd1,  // granted, processor access still running
    RELEASED = 2'd2,  // bus idle, processor held, waiting for acknowledge
    OWN_EXT  = 2'd3   // external agent drives the bus
  } arb_state_t;
endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
    end else begin : g_chain
      logic [WIDTH-1:0] chain_q [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
          chain_q[0] <= async_i;
          for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign sync_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/busarb_fsm.sv
module busarb_fsm
  import busarb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic ack_s,
  input  logic busy_i,
  output logic grant_o,
  output logic free_o,
  output logic hold_o
);
  arb_state_t state_q, state_d;
  logic       grant_q, free_q, hold_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OWN_CPU:  if (req_s && !ack_s) state_d = WAIT_END;
      WAIT_END: begin
        if (!req_s)       state_d = OWN_CPU;
        else if (!busy_i) state_d = RELEASED;
      end
      RELEASED: begin
        if (ack_s)       state_d = OWN_EXT;
        else if (!req_s) state_d = OWN_CPU;
      end
      OWN_EXT:  if (!ack_s) state_d = OWN_CPU;
      default:  state_d = OWN_CPU;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= OWN_CPU;
      grant_q <= 1'b0;
      free_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= (state_d == WAIT_END) || (state_d == RELEASED);
      free_q  <= (state_d == RELEASED);
      hold_q  <= (state_d == RELEASED) || (state_d == OWN_EXT);
    end
  end

  assign grant_o = grant_q;
  assign free_o  = free_q;
  assign hold_o  = hold_q;

  logic owned;
  assign owned = hold_q && !grant_q;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!grant_q && !free_q && !hold_q));

  p_busy_blocks_free_r3: assert property (@(posedge clk) disable iff (rst)
    (grant_q && !free_q && busy_i && req_s) |=> (!free_q && !hold_q));

  p_free_needs_grant_r4: assert property (@(posedge clk) disable iff (rst)
    free_q |-> (grant_q && hold_q));

  p_take_after_free_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(owned) |-> $past(free_q));

  p_return_on_ack_low_r6: assert property (@(posedge clk) disable iff (rst)
    (owned && !ack_s) |=> !hold_q);

  p_no_grant_under_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (!grant_q && !hold_q && ack_s) |=> !grant_q);

  p_withdraw_r9: assert property (@(posedge clk) disable iff (rst)
    (grant_q && !req_s && !ack_s) |=> (!grant_q && !hold_q));
endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_req_i,
  input  logic grant_ack_i,
  input  logic cpu_busy_i,
  output logic bus_grant_o,
  output logic bus_free_o,
  output logic cpu_hold_o
);
  localparam int NUM_ASYNC = 2;

  logic [NUM_ASYNC-1:0] async_in, sync_out;
  assign async_in = {grant_ack_i, bus_req_i};

  busarb_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(async_in),
    .sync_o (sync_out)
  );

  busarb_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .req_s  (sync_out[0]),
    .ack_s  (sync_out[1]),
    .busy_i (cpu_busy_i),
    .grant_o(bus_grant_o),
    .free_o (bus_free_o),
    .hold_o (cpu_hold_o)
  );

  p_hold_when_free_r4: assert property (@(posedge clk) disable iff (rst)
    bus_free_o |-> cpu_hold_o);
endmodule

// File: tb/tb_busarb_ctrl.sv
module tb_busarb_ctrl;
  localparam int SYNC = 2;
  localparam int SETTLE = 6;
  localparam int NV = 15;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, ack = 1'b0, busy = 1'b0;
  logic grant, free, hold;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  busarb_ctrl #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .bus_req_i(req), .grant_ack_i(ack),
    .cpu_busy_i(busy), .bus_grant_o(grant), .bus_free_o(free),
    .cpu_hold_o(hold)
  );

  // {req, ack, busy, exp_grant, exp_free, exp_hold}, each held SETTLE cycles
  localparam logic [5:0] VEC [NV] = '{
    6'b001_000,  // R1 idle, processor busy
    6'b101_100,  // R2 granted, access running
    6'b101_100,  // R3 wait states stretch the access
    6'b111_100,  // R8 early acknowledge ignored
    6'b100_111,  // R3 access ends, bus free
    6'b110_001,  // R5 agent takes the bus
    6'b010_001,  // R6 request dropped, still owned
    6'b110_001,  // R7 new request while owned
    6'b001_000,  // R6 acknowledge dropped, processor back
    6'b010_000,  // R7 stray acknowledge, no grant
    6'b110_000,  // R7 request under acknowledge
    6'b100_111,  // R2 acknowledge low, granted and free
    6'b000_000,  // R9 withdraw after bus-free
    6'b101_100,  // R2 regrant while busy
    6'b001_000   // R9 withdraw while waiting
  };

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {grant,free,hold} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        edges(3);
        chk("R1 reset", {grant, free, hold}, 3'b000);
        rst = 1'b0;
        edges(1);
        chk("R1 after reset", {grant, free, hold}, 3'b000);

        for (int v = 0; v < NV; v++) begin
          {req, ack, busy} = VEC[v][5:3];
          edges(SETTLE);
          chk($sformatf("vector %0d", v), {grant, free, hold}, VEC[v][2:0]);
        end

        // R2 exact grant latency, processor idle
        req = 1'b0; ack = 1'b0; busy = 1'b1;
        edges(SETTLE);
        req = 1'b1;
        edges(SYNC);
        chk("R2 no grant yet", {grant, free, hold}, 3'b000);
        edges(1);
        chk("R2 grant latency", {grant, free, hold}, 3'b100);
        // R3 long wait-state access, then release one edge after busy low
        edges(20);
        chk("R3 stretched access", {grant, free, hold}, 3'b100);
        busy = 1'b0;
        edges(1);
        chk("R3 release latency", {grant, free, hold}, 3'b111);
        // R5 handover, exact
        ack = 1'b1;
        edges(SYNC);
        chk("R5 before ack seen", {grant, free, hold}, 3'b111);
        edges(1);
        chk("R5 ownership", {grant, free, hold}, 3'b001);
        // R6 return latency
        req = 1'b0;
        edges(2);
        ack = 1'b0;
        edges(SYNC);
        chk("R6 still held", {grant, free, hold}, 3'b001);
        edges(1);
        chk("R6 return latency", {grant, free, hold}, 3'b000);
        // R1 mid-run reset while owned
        req = 1'b1; ack = 1'b0;
        edges(SETTLE);
        ack = 1'b1;
        edges(SETTLE);
        chk("R5 owned before reset", {grant, free, hold}, 3'b001);
        rst = 1'b1;
        edges(1);
        chk("R1 mid-run reset", {grant, free, hold}, 3'b000);
        rst = 1'b0; req = 1'b0; ack = 1'b0;
        edges(SETTLE);
        chk("R1 idle after reset", {grant, free, hold}, 3'b000);
      end
      begin
        edges(200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule